// File: doc/BRIEF.md
# Two-Port Synchronous Static Memory

This block is a memory with two fully independent access ports. Each port has its own clock, its own address, write data and controls, and its own read output. Either port can reach any word at any time, including the word the other port is touching in the same cycle. Address, write data and the control inputs are all taken on the rising clock edge of the port that owns them.

A port is enabled by two selects of opposite polarity, so several of these memories can be banked without any decode logic. A read/write input picks the operation. An output enable acts on the read output with no clock involved. A static per-port mode input chooses the read timing. In flow-through timing the word comes out in the cycle right after the edge that took the address. In pipelined timing it comes out one cycle later.

The read side is modelled as a data bus plus a valid flag, not as real tri-state drivers. A bus that is not being driven reads as zero. The storage is built from two banks. Each bank is written by exactly one port, and a read combines both banks with XOR, so neither bank has two writers. The default size is small enough to simulate easily. A 64K x 8 memory is obtained by setting the address width to 16.

Top module: `dpram_sync2`

## Requirements
- R1: A port counts as selected only when `x_cs_n` is 0 and `x_cs` is 1 on its clock edge. With any other select combination, a write changes no stored word and a read never raises `x_rvalid`.
- R2: On an edge where the port is selected and `x_rnw` is 0, `x_wdata` is stored at `x_addr`. Later reads from either port return that value.
- R3: When `x_pipe` is 0, a selected read with `x_rnw` at 1 sets `x_rvalid` to 1 and puts the word at `x_addr` on `x_rdata`, starting right after that edge and lasting until the next edge.
- R4: When `x_pipe` is 1, the read result and its `x_rvalid` appear one clock cycle later than they would with `x_pipe` at 0.
- R5: `x_oe_n` at 1 forces `x_rvalid` and `x_rdata` to 0 at once, with no clock edge. Returning `x_oe_n` to 0 restores the held read result at once.
- R6: After an edge at which the port is not selected, the output is disabled. With `x_pipe` at 0 this happens right after that edge. With `x_pipe` at 1 it happens after the following edge, so the earlier pipelined word is still delivered first.
- R7: With `x_pipe` at 1, `x_rvalid` rises only after two consecutive clock edges following a selected read. The first selected edge after a deselected period does not yet enable the output.
- R8: Both ports may access the same word in the same cycle. If one port writes a word while the other reads it, the reader gets the old value, and the new value is returned from the next access on.
- R9: While reset (`rst_n` at 0) is held, both outputs are disabled: `x_rvalid` and `x_rdata` are 0. The stored words are undefined after reset.
- R10: A write cycle never enables the output. The edge slot that a write takes produces `x_rvalid` at 0 in both timing modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; synchronized internally to each port clock for release |
| a_clk | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A low-active select |
| a_cs | input | 1 | Port A high-active select |
| a_rnw | input | 1 | Port A operation: 1 read, 0 write |
| a_oe_n | input | 1 | Port A asynchronous output enable, low-active |
| a_pipe | input | 1 | Port A static read timing: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when disabled |
| a_rvalid | output | 1 | Port A output-driven flag |
| b_clk | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B low-active select |
| b_cs | input | 1 | Port B high-active select |
| b_rnw | input | 1 | Port B operation: 1 read, 0 write |
| b_oe_n | input | 1 | Port B asynchronous output enable, low-active |
| b_pipe | input | 1 | Port B static read timing: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when disabled |
| b_rvalid | output | 1 | Port B output-driven flag |

## Verification
The timing properties assume three things about the inputs: the timing-mode input of each port is held constant after reset, the two ports never write the same word in the same cycle, and the output enable does not move in the instant the output is sampled. The stimulus keeps within these limits. It ties port A to flow-through and port B to pipelined for the whole run, and it never writes the same address from both ports in one cycle. It also changes the output enable only midway between edges. Both port clocks are driven from one source, so the same-word write/read cases land in a known common cycle and their old-versus-new result can be predicted.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned DPR_ADDR_W_DEF = 10;
  localparam int unsigned DPR_DATA_W_DEF = 8;
  localparam int unsigned DPR_NUM_PORTS  = 2;

  // a port is active only with its low select low and its high select high
  function automatic logic port_sel(input logic cs_n, input logic cs);
    return (~cs_n) & cs;
  endfunction
endpackage

// File: rtl/dpram_rst_sync.sv
module dpram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb sync_n = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [DATA_W-1:0] q0,
  output logic [DATA_W-1:0] q1
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
  end

  assign q0 = mem[ra0];
  assign q1 = mem[ra1];
endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              rnw,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] own_q,
  input  logic [DATA_W-1:0] oth_q,
  output logic              bank_we,
  output logic [DATA_W-1:0] bank_wd,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              sel, rd_go;
  logic              f_v_q, f_v_n, p_v_q, p_v_n;
  logic [DATA_W-1:0] f_d_q, f_d_n, p_d_q, p_d_n;
  logic              st_v;
  logic [DATA_W-1:0] st_d;

  always_comb begin
    sel     = dpram_pkg::port_sel(cs_n, cs);
    rd_go   = sel & rnw;
    bank_we = sel & ~rnw;
    bank_wd = wdata ^ oth_q;
  end

  // next state: flow stage loads on a read, pipe stage follows flow stage
  always_comb begin
    f_v_n = rd_go;
    f_d_n = f_d_q;
    if (rd_go) f_d_n = own_q ^ oth_q;
    p_v_n = f_v_q;
    p_d_n = p_d_q;
    if (f_v_q) p_d_n = f_d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_v_q <= 1'b0;
      f_d_q <= '0;
      p_v_q <= 1'b0;
      p_d_q <= '0;
    end else begin
      f_v_q <= f_v_n;
      f_d_q <= f_d_n;
      p_v_q <= p_v_n;
      p_d_q <= p_d_n;
    end
  end

  always_comb begin
    st_v   = pipe ? p_v_q : f_v_q;
    st_d   = pipe ? p_d_q : f_d_q;
    rvalid = st_v & ~oe_n;
    rdata  = rvalid ? st_d : '0;
  end

  assert_flow_read_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && rd_go) |=> (rvalid || oe_n));
  assert_pipe_read_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && rd_go) |=> ##1 (rvalid || oe_n));
  assert_flow_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !sel) |=> !rvalid);
  assert_pipe_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && !sel) |=> ##1 !rvalid);
  assert_pipe_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && rvalid) |-> $past(rd_go, 2));
  assert_flow_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && bank_we) |=> !rvalid);
  assert_pipe_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && bank_we) |=> ##1 !rvalid);
endmodule

// File: rtl/dpram_sync2.sv
module dpram_sync2 #(
  parameter int unsigned ADDR_W = dpram_pkg::DPR_ADDR_W_DEF,
  parameter int unsigned DATA_W = dpram_pkg::DPR_DATA_W_DEF
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_rnw,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_clk,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_rnw,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  localparam int unsigned NP = dpram_pkg::DPR_NUM_PORTS;

  logic              clk_v   [NP];
  logic              cs_n_v  [NP];
  logic              cs_v    [NP];
  logic              rnw_v   [NP];
  logic              oe_n_v  [NP];
  logic              pipe_v  [NP];
  logic [ADDR_W-1:0] addr_v  [NP];
  logic [DATA_W-1:0] wdata_v [NP];
  logic [DATA_W-1:0] rdata_v [NP];
  logic              rvld_v  [NP];
  logic              rst_s_v [NP];
  logic              we_v    [NP];
  logic [DATA_W-1:0] wd_v    [NP];
  logic [DATA_W-1:0] q0_v    [NP];
  logic [DATA_W-1:0] q1_v    [NP];

  assign clk_v[0]   = a_clk;   assign clk_v[1]   = b_clk;
  assign cs_n_v[0]  = a_cs_n;  assign cs_n_v[1]  = b_cs_n;
  assign cs_v[0]    = a_cs;    assign cs_v[1]    = b_cs;
  assign rnw_v[0]   = a_rnw;   assign rnw_v[1]   = b_rnw;
  assign oe_n_v[0]  = a_oe_n;  assign oe_n_v[1]  = b_oe_n;
  assign pipe_v[0]  = a_pipe;  assign pipe_v[1]  = b_pipe;
  assign addr_v[0]  = a_addr;  assign addr_v[1]  = b_addr;
  assign wdata_v[0] = a_wdata; assign wdata_v[1] = b_wdata;
  assign a_rdata    = rdata_v[0];
  assign a_rvalid   = rvld_v[0];
  assign b_rdata    = rdata_v[1];
  assign b_rvalid   = rvld_v[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int unsigned Q = NP - 1 - p;

    dpram_rst_sync #(.STAGES(2)) u_rst (
      .clk(clk_v[p]), .rst_n(rst_n), .rst_s_n(rst_s_v[p])
    );

    dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk_v[p]), .we(we_v[p]), .waddr(addr_v[p]), .wd(wd_v[p]),
      .ra0(addr_v[p]), .ra1(addr_v[Q]), .q0(q0_v[p]), .q1(q1_v[p])
    );

    dpram_port #(.DATA_W(DATA_W)) u_port (
      .clk(clk_v[p]), .rst_n(rst_s_v[p]), .cs_n(cs_n_v[p]), .cs(cs_v[p]),
      .rnw(rnw_v[p]), .oe_n(oe_n_v[p]), .pipe(pipe_v[p]), .wdata(wdata_v[p]),
      .own_q(q0_v[p]), .oth_q(q1_v[Q]), .bank_we(we_v[p]), .bank_wd(wd_v[p]),
      .rdata(rdata_v[p]), .rvalid(rvld_v[p])
    );
  end

  always_comb begin
    if (!rst_n) assert_reset_quiet_R9: assert (!a_rvalid && !b_rvalid);
  end
endmodule

// File: tb/dpram_sync2_tb.sv
module dpram_sync2_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_cs_n, a_cs, a_rnw, a_oe_n;
  logic          b_cs_n, b_cs, b_rnw, b_oe_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic          a_rvalid, b_rvalid;
  logic [DW-1:0] model [N];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  dpram_sync2 #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .rst_n(rst_n),
    .a_clk(clk), .a_cs_n(a_cs_n), .a_cs(a_cs), .a_rnw(a_rnw), .a_oe_n(a_oe_n),
    .a_pipe(1'b0), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_rvalid(a_rvalid),
    .b_clk(clk), .b_cs_n(b_cs_n), .b_cs(b_cs), .b_rnw(b_rnw), .b_oe_n(b_oe_n),
    .b_pipe(1'b1), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_rvalid(b_rvalid)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_a(input logic c0, input logic c1, input logic rw,
                       input int ad, input logic [DW-1:0] d);
    a_cs_n = c0; a_cs = c1; a_rnw = rw; a_addr = AW'(ad); a_wdata = d;
  endtask

  task automatic set_b(input logic c0, input logic c1, input logic rw,
                       input int ad, input logic [DW-1:0] d);
    b_cs_n = c0; b_cs = c1; b_rnw = rw; b_addr = AW'(ad); b_wdata = d;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_oe_n = 1'b0; b_oe_n = 1'b0;
    set_a(1, 1, 1, 0, 0); set_b(1, 1, 1, 0, 0);
    repeat (3) step();
    chk("R9 port A under reset", {a_rvalid, a_rdata}, '0);
    chk("R9 port B under reset", {b_rvalid, b_rdata}, '0);
    rst_n = 1'b1;
    repeat (3) step();

    // fill through port A; write slots never drive the output
    for (int i = 0; i < N; i++) begin
      set_a(0, 1, 0, i, pat(i));
      step();
      chk("R10 write slot A", {a_rvalid, a_rdata}, '0);
      model[i] = pat(i);
    end
    set_a(1, 1, 1, 0, 0); step();

    // sweep reads on both ports: flow on A, pipelined on B
    for (int i = 0; i < N; i++) begin
      set_a(0, 1, 1, i, 0); set_b(0, 1, 1, i, 0);
      step();
      chk("R3 flow read A", {a_rvalid, a_rdata}, {1'b1, model[i]});
      if (i == 0) chk("R7 first pipelined edge B", {b_rvalid, b_rdata}, '0);
      else        chk("R4 pipelined read B", {b_rvalid, b_rdata}, {1'b1, model[i-1]});
    end

    // deselect through each select pin
    set_a(1, 1, 1, 0, 0); set_b(0, 0, 1, 0, 0);
    step();
    chk("R6 flow deselect A", {a_rvalid, a_rdata}, '0);
    chk("R6 pipelined tail B", {b_rvalid, b_rdata}, {1'b1, model[N-1]});
    step();
    chk("R6 pipelined deselect B", {b_rvalid, b_rdata}, '0);

    // non-selecting combinations have no effect
    for (int c = 0; c < 3; c++) begin
      logic c0, c1;
      c0 = (c != 1); c1 = (c == 0);
      set_a(c0, c1, 0, 3, 8'hFF); step();
      chk("R1 unselected write A", {a_rvalid, a_rdata}, '0);
      set_a(c0, c1, 1, 3, 0); step();
      chk("R1 unselected read A", {a_rvalid, a_rdata}, '0);
    end
    set_a(0, 1, 1, 3, 0); step();
    chk("R1 word kept after unselected writes", {a_rvalid, a_rdata}, {1'b1, model[3]});

    // asynchronous output enable
    set_a(0, 1, 1, 5, 0); step();
    chk("R5 read before oe", {a_rvalid, a_rdata}, {1'b1, model[5]});
    a_oe_n = 1'b1; #1;
    chk("R5 oe high disables", {a_rvalid, a_rdata}, '0);
    a_oe_n = 1'b0; #1;
    chk("R5 oe low restores", {a_rvalid, a_rdata}, {1'b1, model[5]});
    set_a(1, 1, 1, 0, 0); step(); step();

    // same-word write against read, both directions
    set_a(0, 1, 0, 7, 8'hA5); set_b(0, 1, 1, 7, 0);
    step();
    chk("R10 write slot A collision", {a_rvalid, a_rdata}, '0);
    set_a(0, 1, 1, 9, 0); set_b(0, 1, 0, 9, 8'h5A);
    step();
    chk("R8 A reads old during B write", {a_rvalid, a_rdata}, {1'b1, model[9]});
    chk("R8 B read old during A write", {b_rvalid, b_rdata}, {1'b1, model[7]});
    model[7] = 8'hA5; model[9] = 8'h5A;
    set_a(0, 1, 1, 9, 0); set_b(0, 1, 1, 7, 0);
    step();
    chk("R8 A sees new word", {a_rvalid, a_rdata}, {1'b1, model[9]});
    chk("R10 pipelined write slot B", {b_rvalid, b_rdata}, '0);
    set_a(1, 1, 1, 0, 0); set_b(1, 1, 1, 0, 0);
    step();
    chk("R8 B sees new word", {b_rvalid, b_rdata}, {1'b1, model[7]});
    step();

    // both ports read one word together
    set_a(0, 1, 1, 2, 0); set_b(0, 1, 1, 2, 0);
    step();
    chk("R8 shared read A", {a_rvalid, a_rdata}, {1'b1, model[2]});
    set_a(1, 1, 1, 0, 0); set_b(0, 1, 1, 2, 0);
    step();
    chk("R8 shared read B", {b_rvalid, b_rdata}, {1'b1, model[2]});
    set_b(1, 1, 1, 0, 0); step(); step();

    // port B writes, port A reads everything back
    set_b(0, 1, 0, 12, 8'h3C); step(); model[12] = 8'h3C;
    set_b(1, 1, 1, 0, 0);
    for (int i = 0; i < N; i++) begin
      set_a(0, 1, 1, i, 0); step();
      chk("R2 readback A", {a_rvalid, a_rdata}, {1'b1, model[i]});
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule